// File: doc/BRIEF.md
# Four-Mode Serial Port Engine

An 8-bit serial port with four operating modes picked by a 2-bit mode field. Mode 0 is a synchronous master: it drives a shift clock and shifts out 8 bits while it samples 8 bits in. Mode 1 is half-duplex asynchronous framing with one start bit, 8 data bits and one stop bit. It transmits on command and receives whenever it is idle. Mode 2 is a synchronous master that sends a low start bit before the 8 clocked data bits. Mode 3 is a receive-only bus slave. It waits for a start condition, takes 8 bits on the rising edges of the external clock, and completes on a stop condition. Data is always sent and received least significant bit first.

Transmit and receive share one 8-bit shift register. A single 8-bit reload value N sets the timing. The synchronous bit period is 2(N+1) clock cycles, which spans 2 to 512 cycles. The asynchronous bit time is 8(N+1) cycles, which spans 8 to 2048 cycles. Software drives the block through a small register interface with three registers. A done flag, gated by an enable bit, raises the interrupt.

The register map: address 0 is control, address 1 is the divider N, address 2 is data. Address 3 reads zero. The control bits are: [1:0] mode, [2] go on write and busy on read, [3] done, [4] interrupt enable, [5] framing error (read only). Bits [7:6] read zero.

Top module: `sio4_port`

## Requirements
- R1: After reset every register reads 0, sck_o and sd_o are high and irq_o is low.
- R2: In modes 0 and 2 each shift-clock half period lasts N+1 cycles. In mode 1 each bit lasts 8(N+1) cycles. The first period is counted from the clock edge that captures the go write.
- R3: In mode 0 a go write drives sck_o low and puts data bit 0 on sd_o in the same edge. On each later falling sck_o the next bit appears. sd_i is sampled at each rising sck_o. After 8 clocks, sck_o and sd_o return high. sck_oe_o is high in modes 0 and 2 and low in modes 1 and 3.
- R4: In mode 2, sd_o is low for one full bit period (two half periods) with sck_o high, and then the 8 bits follow exactly as in mode 0.
- R5: A mode 1 transmit sends a low start bit, then bits 0 to 7, then a high stop bit. Reading data afterwards returns 8'hFF.
- R6: In mode 1 when idle, a falling edge on sd_i is confirmed at mid-bit. A pulse that has returned high by then is dropped: there is no done and the port goes back to idle. A confirmed frame is sampled at mid-bit and its byte appears in the data register.
- R7: If the mode 1 stop bit is sampled low, control bit 5 is set, the received byte is still delivered and done is set. Bit 5 clears at the next go or the next reception start.
- R8: In mode 3, a start condition is sd_i falling while sck_i is high. Bits are then taken on sck_i rising edges. A stop condition, sd_i rising while sck_i is high, after 8 bits sets done with the byte in the data register.
- R9: Done (control bit 3) is set at the end of each frame. irq_o is high exactly when done and enable (bit 4) are both set. A control write with bit 3 = 0 clears done, and a write with bit 3 = 1 leaves it unchanged.
- R10: While busy, writes to data, to the divider, to the mode field and to go are ignored, and control bit 2 reads 1.
- R11: In mode 3, a stop condition before 8 bits have been received drops the frame without setting done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| irq_o | output | 1 | Done interrupt |
| sck_i | input | 1 | External shift clock (mode 3) |
| sck_o | output | 1 | Generated shift clock |
| sck_oe_o | output | 1 | Shift clock output enable |
| sd_i | input | 1 | Serial data in |
| sd_o | output | 1 | Serial data out |
| sd_oe_o | output | 1 | Serial data output enable (transmit in progress) |

## Verification
Some properties are checked by assertions on every cycle. Both lines are high whenever the engine is idle. The baud tick never fires on two consecutive cycles when N is nonzero. The mode 2 start bit holds the clock high and the data line low. Receive states never drive the data line. Done rises only at the end of an active frame. The mode field cannot change while a frame is running. Other behaviour only the bench scenarios can show: the bit order and exact edge timing of each transmit mode, compared against a behavioural model on every cycle, mid-bit glitch rejection, framing-error delivery, the start and stop conditions of mode 3 including early-stop abort, and write protection while busy.

// File: rtl/sio4_pkg.sv
package sio4_pkg;
  typedef enum logic [1:0] {
    MODE_SYNC      = 2'd0,
    MODE_ASYNC     = 2'd1,
    MODE_BUS_START = 2'd2,
    MODE_BUS_COND  = 2'd3
  } sio_mode_e;

  typedef enum logic [1:0] {ST_IDLE, ST_TX, ST_ARX, ST_BRX} sio_state_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_DIV  = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  localparam int CTRL_GO   = 2;
  localparam int CTRL_DONE = 3;
  localparam int CTRL_IE   = 4;
  localparam int CTRL_FERR = 5;

  // ticks per asynchronous bit, start-bit ticks in mode 2
  localparam int ASYNC_OS         = 8;
  localparam int SYNC_START_TICKS = 2;
endpackage

// File: rtl/sio4_baud.sv
module sio4_baud #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] div_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || !en_i)    cnt_q <= '0;
    else if (tick_o)            cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sio4_insync.sv
module sio4_insync #(
  parameter int   W       = 2,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES*W-1:0] chain_q;

  if (STAGES == 1) begin : g_single
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {(STAGES*W){RST_VAL}};
      else         chain_q <= d_i;
    end
  end else begin : g_multi
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {(STAGES*W){RST_VAL}};
      else         chain_q <= {chain_q[(STAGES-1)*W-1:0], d_i};
    end
  end

  assign q_o = chain_q[STAGES*W-1 -: W];
endmodule

// File: rtl/sio4_cond.sv
module sio4_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic sd_i,
  output logic sck_rise_o,
  output logic sd_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic sck_q, sd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b1;
      sd_q  <= 1'b1;
    end else begin
      sck_q <= sck_i;
      sd_q  <= sd_i;
    end
  end

  assign sck_rise_o = !sck_q && sck_i;
  assign sd_fall_o  = sd_q && !sd_i;
  // data edge while clock held high
  assign start_o    = sd_fall_o && sck_q && sck_i;
  assign stop_o     = !sd_q && sd_i && sck_q && sck_i;
endmodule

// File: rtl/sio4_port.sv
module sio4_port
  import sio4_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          irq_o,
  input  logic          sck_i,
  output logic          sck_o,
  output logic          sck_oe_o,
  input  logic          sd_i,
  output logic          sd_o,
  output logic          sd_oe_o
);
  localparam int PH_W = $clog2(ASYNC_OS*(DW+2)+1);
  localparam int OS_W = $clog2(ASYNC_OS);
  localparam int BI_W = PH_W - OS_W;
  localparam int BC_W = $clog2(DW+1);
  localparam logic [PH_W-1:0] SYNC_END   = PH_W'(2*DW);
  localparam logic [PH_W-1:0] ASYNC_MID  = PH_W'(ASYNC_OS/2);
  localparam logic [OS_W-1:0] OS_HALF    = OS_W'(ASYNC_OS/2);
  localparam logic [BI_W-1:0] ASYNC_STOP = BI_W'(DW+1);
  localparam logic [BI_W-1:0] ASYNC_END  = BI_W'(DW+2);
  localparam logic [BC_W-1:0] BITS_FULL  = BC_W'(DW);

  sio_state_e    st_q;
  sio_mode_e     mode_q, wr_mode;
  logic [DW-1:0] shift_q, div_q;
  logic          done_q, ie_q, ferr_q, sck_q, sd_q;
  logic [PH_W-1:0] ph_q, ph_n, off, rel;
  logic [BI_W-1:0] bidx;
  logic [OS_W-1:0] slot;
  logic [BC_W-1:0] bcnt_q;

  logic [1:0] line_s;
  logic       rx_sck, rx_sd;
  logic       sck_rise, sd_fall, start_c, stop_c;
  logic       tick, busy, wr_ctrl, go_req, arx_start, baud_clr, baud_en;

  sio4_insync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i({sck_i, sd_i}), .q_o(line_s)
  );
  assign rx_sck = line_s[1];
  assign rx_sd  = line_s[0];

  sio4_cond u_cond (
    .clk_i(clk_i), .rst_ni(rst_ni), .sck_i(rx_sck), .sd_i(rx_sd),
    .sck_rise_o(sck_rise), .sd_fall_o(sd_fall), .start_o(start_c), .stop_o(stop_c)
  );

  sio4_baud #(.W(DW)) u_baud (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(baud_clr), .en_i(baud_en),
    .div_i(div_q), .tick_o(tick)
  );

  assign busy      = (st_q != ST_IDLE);
  assign wr_ctrl   = reg_we_i && (reg_addr_i == ADDR_CTRL);
  assign wr_mode   = sio_mode_e'(reg_wdata_i[1:0]);
  assign go_req    = wr_ctrl && !busy && reg_wdata_i[CTRL_GO] && (wr_mode != MODE_BUS_COND);
  assign arx_start = !busy && !wr_ctrl && (mode_q == MODE_ASYNC) && sd_fall;
  assign baud_clr  = go_req || arx_start;
  assign baud_en   = (st_q == ST_TX) || (st_q == ST_ARX);

  assign ph_n = ph_q + 1'b1;
  assign off  = (mode_q == MODE_BUS_START) ? PH_W'(SYNC_START_TICKS) : '0;
  assign rel  = ph_n - off;
  assign bidx = ph_n[PH_W-1:OS_W];
  assign slot = ph_n[OS_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      mode_q  <= MODE_SYNC;
      shift_q <= '0;
      div_q   <= '0;
      done_q  <= 1'b0;
      ie_q    <= 1'b0;
      ferr_q  <= 1'b0;
      sck_q   <= 1'b1;
      sd_q    <= 1'b1;
      ph_q    <= '0;
      bcnt_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        ie_q <= reg_wdata_i[CTRL_IE];
        if (!reg_wdata_i[CTRL_DONE]) done_q <= 1'b0;
        if (!busy) mode_q <= wr_mode;
      end
      if (reg_we_i && (reg_addr_i == ADDR_DIV)  && !busy) div_q   <= reg_wdata_i;
      if (reg_we_i && (reg_addr_i == ADDR_DATA) && !busy) shift_q <= reg_wdata_i;

      unique case (st_q)
        ST_IDLE: begin
          if (go_req) begin
            st_q   <= ST_TX;
            ph_q   <= '0;
            ferr_q <= 1'b0;
            unique case (wr_mode)
              MODE_SYNC:      begin sck_q <= 1'b0; sd_q <= shift_q[0]; end
              MODE_BUS_START: begin sck_q <= 1'b1; sd_q <= 1'b0; end
              default:        sd_q <= 1'b0;
            endcase
          end else if (arx_start) begin
            st_q   <= ST_ARX;
            ph_q   <= '0;
            ferr_q <= 1'b0;
          end else if ((mode_q == MODE_BUS_COND) && !wr_ctrl && start_c) begin
            st_q   <= ST_BRX;
            bcnt_q <= '0;
            ferr_q <= 1'b0;
          end
        end

        ST_TX: if (tick) begin
          ph_q <= ph_n;
          if (mode_q == MODE_ASYNC) begin
            if (slot == '0) begin
              if (bidx == ASYNC_END) begin
                st_q   <= ST_IDLE;
                done_q <= 1'b1;
                sd_q   <= 1'b1;
              end else if (bidx == ASYNC_STOP) begin
                sd_q <= 1'b1;
              end else begin
                sd_q    <= shift_q[0];
                shift_q <= {1'b1, shift_q[DW-1:1]};
              end
            end
          end else if (ph_n >= off) begin
            if (rel == SYNC_END) begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
              sck_q  <= 1'b1;
              sd_q   <= 1'b1;
            end else if (rel[0]) begin
              sck_q   <= 1'b1;
              shift_q <= {sd_i, shift_q[DW-1:1]};
            end else begin
              sck_q <= 1'b0;
              sd_q  <= shift_q[0];
            end
          end
        end

        ST_ARX: if (tick) begin
          ph_q <= ph_n;
          if (ph_n == ASYNC_MID) begin
            if (rx_sd) st_q <= ST_IDLE;  // glitch, not a start bit
          end else if (slot == OS_HALF) begin
            if (bidx == ASYNC_STOP) begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
              ferr_q <= !rx_sd;
            end else begin
              shift_q <= {rx_sd, shift_q[DW-1:1]};
            end
          end
        end

        ST_BRX: begin
          if (start_c) begin
            bcnt_q <= '0;
          end else if (stop_c) begin
            st_q <= ST_IDLE;
            if (bcnt_q == BITS_FULL) done_q <= 1'b1;
          end else if (sck_rise && (bcnt_q != BITS_FULL)) begin
            shift_q <= {rx_sd, shift_q[DW-1:1]};
            bcnt_q  <= bcnt_q + 1'b1;
          end
        end

        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADDR_CTRL: begin
        reg_rdata_o[1:0]       = mode_q;
        reg_rdata_o[CTRL_GO]   = busy;
        reg_rdata_o[CTRL_DONE] = done_q;
        reg_rdata_o[CTRL_IE]   = ie_q;
        reg_rdata_o[CTRL_FERR] = ferr_q;
      end
      ADDR_DIV:  reg_rdata_o = div_q;
      ADDR_DATA: reg_rdata_o = shift_q;
      default:   reg_rdata_o = '0;
    endcase
  end

  assign irq_o    = done_q && ie_q;
  assign sck_o    = sck_q;
  assign sd_o     = sd_q;
  assign sck_oe_o = (mode_q == MODE_SYNC) || (mode_q == MODE_BUS_START);
  assign sd_oe_o  = (st_q == ST_TX);
endmodule

// File: rtl/sio4_chk.sv
module sio4_chk
  import sio4_pkg::*;
#(
  parameter int DW   = 8,
  parameter int PH_W = 7
) (
  input logic            clk_i,
  input logic            rst_ni,
  input sio_state_e      st_q,
  input sio_mode_e       mode_q,
  input logic            tick,
  input logic [DW-1:0]   div_q,
  input logic [PH_W-1:0] ph_q,
  input logic            done_q,
  input logic            sck_o,
  input logic            sd_o,
  input logic            sd_oe_o
);
  // R2
  tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && (div_q != '0)) |=> !tick);

  // R3
  idle_lines_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> (sck_o && sd_o));

  // R4
  start_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_TX) && (mode_q == MODE_BUS_START) && (ph_q < PH_W'(SYNC_START_TICKS)))
      |-> (sck_o && !sd_o));

  // R6
  rx_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_ARX) || (st_q == ST_BRX)) |-> (!sd_oe_o && sck_o));

  // R9
  done_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> ($past(st_q) != ST_IDLE));

  // R10
  mode_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |=> $stable(mode_q));
endmodule

bind sio4_port sio4_chk #(.DW(DW), .PH_W(PH_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .st_q   (st_q),
  .mode_q (mode_q),
  .tick   (tick),
  .div_q  (div_q),
  .ph_q   (ph_q),
  .done_q (done_q),
  .sck_o  (sck_o),
  .sd_o   (sd_o),
  .sd_oe_o(sd_oe_o)
);

// File: tb/tb_sio4_port.sv
module tb_sio4_port;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [1:0] reg_addr_i = 2'd0;
  logic [7:0] reg_wdata_i = 8'd0;
  logic [7:0] reg_rdata_o;
  logic       irq_o, sck_o, sck_oe_o, sd_o, sd_oe_o;
  logic       sck_i = 1'b1;
  logic       sd_i = 1'b1;

  int nchk = 0;
  int nerr = 0;
  logic [7:0] rv;

  sio4_port dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe_o(sck_oe_o),
    .sd_i(sd_i), .sd_o(sd_o), .sd_oe_o(sd_oe_o)
  );

  always #10 clk_i = ~clk_i;

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  // behavioural model of a transmit frame, compared every cycle
  task automatic run_tx(input int m, input logic [7:0] d, input logic [7:0] pat,
                        input int n, input string tag);
    int off, total, k, r, esck, esd;
    wr(2'd1, 8'(n));
    wr(2'd2, d);
    off   = (m == 2) ? 2 : 0;
    total = (m == 1) ? 80 : off + 16;
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = 2'd0; reg_wdata_i = 8'h14 | 8'(m);
    @(posedge clk_i);
    for (int t = 0; t < (total + 2) * (n + 1); t++) begin
      @(negedge clk_i);
      reg_we_i = 1'b0;
      k = t / (n + 1);
      if (k >= total) begin
        esck = 1; esd = 1;
      end else if (m == 1) begin
        esck = 1;
        esd  = (k < 8) ? 0 : (k < 72) ? int'(d[k/8-1]) : 1;
      end else if (k < off) begin
        esck = 1; esd = 0;
      end else begin
        r = k - off;
        esck = r % 2;
        esd  = int'(d[r/2]);
      end
      chk({tag, " sck (R2)"}, int'(sck_o), esck);
      chk({tag, " sd"}, int'(sd_o), esd);
      chk("R9 irq at frame end", int'(irq_o), (k >= total) ? 1 : 0);
      if (m != 1 && k >= off && k - off < 16) sd_i = pat[(k-off)/2];
      else sd_i = 1'b1;
    end
    sd_i = 1'b1;
    rd(2'd2, rv);
    chk({tag, " rx data"}, int'(rv), (m == 1) ? 8'hFF : int'(pat));
  endtask

  task automatic send_async(input logic [7:0] b, input logic stopv, input int n);
    int bt;
    bt = 8 * (n + 1);
    @(negedge clk_i);
    sd_i = 1'b0; repeat (bt) @(negedge clk_i);
    for (int j = 0; j < 8; j++) begin
      sd_i = b[j]; repeat (bt) @(negedge clk_i);
    end
    sd_i = stopv; repeat (bt) @(negedge clk_i);
    sd_i = 1'b1; repeat (10) @(negedge clk_i);
  endtask

  task automatic send_bus(input logic [7:0] b, input int nbits);
    @(negedge clk_i);
    sd_i = 1'b0; repeat (4) @(negedge clk_i);
    for (int j = 0; j < nbits; j++) begin
      sck_i = 1'b0; repeat (2) @(negedge clk_i);
      sd_i = b[j];  repeat (2) @(negedge clk_i);
      sck_i = 1'b1; repeat (4) @(negedge clk_i);
    end
    sck_i = 1'b0; repeat (2) @(negedge clk_i);
    sd_i = 1'b0;  repeat (2) @(negedge clk_i);
    sck_i = 1'b1; repeat (4) @(negedge clk_i);
    sd_i = 1'b1;  repeat (6) @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    chk("R1 sck_o", int'(sck_o), 1);
    chk("R1 sd_o", int'(sd_o), 1);
    chk("R1 irq_o", int'(irq_o), 0);
    rd(2'd0, rv); chk("R1 ctrl", int'(rv), 0);
    rd(2'd1, rv); chk("R1 div", int'(rv), 0);
    rd(2'd2, rv); chk("R1 data", int'(rv), 0);

    // R3 mode 0 at two dividers
    run_tx(0, 8'hA5, 8'h3C, 0, "R3 mode0 n0");
    run_tx(0, 8'h81, 8'hC3, 4, "R3 mode0 n4");
    chk("R3 sck_oe mode0", int'(sck_oe_o), 1);

    // R4 mode 2 start bit
    run_tx(2, 8'h5A, 8'h96, 1, "R4 mode2");

    // R5 mode 1 transmit
    run_tx(1, 8'h6B, 8'h00, 1, "R5 mode1 tx");
    chk("R3 sck_oe mode1", int'(sck_oe_o), 0);

    // R9 done and interrupt enable
    rd(2'd0, rv); chk("R9 ctrl after tx", int'(rv), 8'h19);
    wr(2'd0, 8'h09);
    chk("R9 irq masked", int'(irq_o), 0);
    rd(2'd0, rv); chk("R9 done kept", int'(rv), 8'h09);
    wr(2'd0, 8'h11);
    chk("R9 irq after clear", int'(irq_o), 0);
    rd(2'd0, rv); chk("R9 done cleared", int'(rv), 8'h11);

    // R10 writes ignored while busy
    wr(2'd1, 8'd5);
    sd_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = 2'd0; reg_wdata_i = 8'h14;
    @(negedge clk_i);
    reg_we_i = 1'b0;
    repeat (40) @(negedge clk_i);
    wr(2'd2, 8'h5A);
    wr(2'd1, 8'd9);
    wr(2'd0, 8'h16);
    rd(2'd0, rv); chk("R10 busy ctrl", int'(rv), 8'h14);
    rd(2'd1, rv); chk("R10 div locked", int'(rv), 5);
    repeat (80) @(negedge clk_i);
    rd(2'd0, rv); chk("R10 ctrl after", int'(rv), 8'h18);
    rd(2'd2, rv); chk("R10 data locked", int'(rv), 8'hFF);

    // R6 asynchronous receive
    wr(2'd0, 8'h01);
    wr(2'd1, 8'd3);
    send_async(8'hC4, 1'b1, 3);
    rd(2'd2, rv); chk("R6 rx byte", int'(rv), 8'hC4);
    rd(2'd0, rv); chk("R6 rx ctrl", int'(rv), 8'h09);

    // R6 glitch rejection
    wr(2'd0, 8'h01);
    @(negedge clk_i);
    sd_i = 1'b0; repeat (8) @(negedge clk_i);
    sd_i = 1'b1; repeat (40) @(negedge clk_i);
    rd(2'd0, rv); chk("R6 glitch ctrl", int'(rv), 8'h01);
    rd(2'd2, rv); chk("R6 glitch data", int'(rv), 8'hC4);

    // R7 framing error
    send_async(8'h3D, 1'b0, 3);
    rd(2'd0, rv); chk("R7 ferr ctrl", int'(rv), 8'h29);
    rd(2'd2, rv); chk("R7 ferr data", int'(rv), 8'h3D);

    // R8 mode 3 frame
    wr(2'd0, 8'h03);
    chk("R3 sck_oe mode3", int'(sck_oe_o), 0);
    send_bus(8'hB2, 8);
    rd(2'd0, rv); chk("R8 bus ctrl", int'(rv), 8'h0B);
    rd(2'd2, rv); chk("R8 bus data", int'(rv), 8'hB2);

    // R11 early stop
    wr(2'd0, 8'h03);
    send_bus(8'hFF, 3);
    rd(2'd0, rv); chk("R11 abort ctrl", int'(rv), 8'h03);
    chk("R11 abort irq", int'(irq_o), 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule